// File: doc/BRIEF.md
# Dual-Bank Prioritized Interrupt Controller

This block gathers 32 interrupt sources and presents them to a processor on two request lines: a normal request and a fast request. Each request line belongs to a bank. Each bank has its own enable mask, its own priority ceiling and its own pending latches. The three per-line settings are shared by both banks: input polarity, capture mode (level-following or edge-latched) and a 4-bit priority. Software reaches everything through a plain 32-bit register read/write port. A read has no side effect except at a bank's acknowledge offset, where the read clears that bank's latched pending state.

For each bank, the block reports the filtered pending set. It also reports the number of the line to service next, chosen by priority value and then by line number. It drives that bank's request line while the filtered set is non-empty. Read data is combinational from the address. Writes and acknowledge side effects take place at the rising clock edge of the cycle in which the strobe is high.

Top module: `intc_dual_bank`

## Requirements
- R1: After reset, both banks' enable masks are zero, both request lines are low, both ceilings read 0xF, the polarity register reads 0xFFFFFFFF, the capture register reads 0 and every priority word reads 0.
- R2: In a bank, a write to offset +0x08 sets the enable bits where the write data holds 1, and a write to +0x0C clears them where it holds 1. Bits written 0 are left unchanged. A read of either offset returns the bank's enable mask.
- R3: The polarity register at 0x200 holds one bit per line. A 1 passes the input through unchanged and a 0 inverts it. Offset +0x04 of a bank reads the per-line state before enable and ceiling filtering.
- R4: The capture register at 0x204 holds one bit per line. With a 0, the line follows its adjusted input. With a 1, a 0-to-1 change of the adjusted input sets the line's pending latch in both banks, and the latch stays set with no further input until that bank is acknowledged.
- R5: A read of bank offset +0x28 returns the bank's status word and clears all of that bank's pending latches at the clock edge. The other bank's latches are unaffected. A new edge in the same cycle as the acknowledge sets its latch.
- R6: Bank offset +0x00 reads the per-line state ANDed with the enable mask and with the ceiling filter. The bank's request output is high exactly when this word is nonzero.
- R7: Bank offset +0x2C holds a 4-bit ceiling in its low bits. A line passes the filter when its priority value is less than or equal to the ceiling, so 0xF admits every priority.
- R8: The priority of line n is the low 4 bits of the word at 0x300 + 4*n. A value of 0 is the most urgent.
- R9: Bank offset +0x20 returns the number of the status line with the smallest priority value, choosing the lowest line number on a tie. It returns 32 when the status word is zero.
- R10: The normal bank sits at base 0x000 and the fast bank at base 0x100. Each bank has its own enables and ceiling, while polarity, capture and priorities are common to both banks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| src_i | input | 32 | Interrupt source inputs, one per line |
| addr_i | input | 12 | Register byte address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe; triggers the acknowledge side effect |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Normal-bank request |
| fiq_o | output | 1 | Fast-bank request |

## Verification
Assertions check on every cycle that set and clear writes land in the enable mask, that latched lines never drop without an acknowledge, and that an acknowledge without a new edge empties the latches. They also check that a request line stays low while its enable mask is zero, and that the next-line number is 32 exactly when the request is low. Only the bench scenarios can show that the arbitration order, the ceiling comparison, the polarity handling, the independence of the two banks and the reset values give the correct numbers at the register port.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned LINES  = 32;
  localparam int unsigned PRIO_W = 4;
  localparam int unsigned ADDR_W = 12;

  localparam logic [ADDR_W-1:0] BANK0_BASE = 12'h000;
  localparam logic [ADDR_W-1:0] BANK1_BASE = 12'h100;
  localparam logic [ADDR_W-1:0] POL_ADDR   = 12'h200;
  localparam logic [ADDR_W-1:0] CAP_ADDR   = 12'h204;
  localparam logic [ADDR_W-1:0] PRIO_BASE  = 12'h300;

  typedef enum logic [7:0] {
    OFS_STATUS = 8'h00,
    OFS_RAW    = 8'h04,
    OFS_ENSET  = 8'h08,
    OFS_ENCLR  = 8'h0C,
    OFS_CUR    = 8'h20,
    OFS_ACK    = 8'h28,
    OFS_CEIL   = 8'h2C
  } bank_ofs_e;
endpackage

// File: rtl/intc_pick.sv
module intc_pick #(
  parameter int unsigned N  = 32,
  parameter int unsigned PW = 4,
  localparam int unsigned IW = $clog2(N) + 1
) (
  input  logic [N-1:0]    cand_i,
  input  logic [N*PW-1:0] prio_i,
  output logic [IW-1:0]   win_o
);
  logic [PW:0]   best;
  logic [IW-1:0] idx;

  always_comb begin
    best = {1'b1, {PW{1'b0}}};
    idx  = IW'(N);
    for (int i = 0; i < N; i++) begin
      if (cand_i[i] && ({1'b0, prio_i[i*PW +: PW]} < best)) begin
        best = {1'b0, prio_i[i*PW +: PW]};
        idx  = IW'(i);
      end
    end
  end

  assign win_o = idx;
endmodule

// File: rtl/intc_bank.sv
module intc_bank #(
  parameter int unsigned N  = 32,
  parameter int unsigned PW = 4,
  localparam int unsigned IW = $clog2(N) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    adj_i,
  input  logic [N-1:0]    rise_i,
  input  logic [N-1:0]    cap_i,
  input  logic [N*PW-1:0] prio_i,
  input  logic            en_set_i,
  input  logic            en_clr_i,
  input  logic            ceil_we_i,
  input  logic            ack_i,
  input  logic [N-1:0]    wdata_i,
  output logic [N-1:0]    raw_o,
  output logic [N-1:0]    en_o,
  output logic [N-1:0]    latch_o,
  output logic [N-1:0]    stat_o,
  output logic [PW-1:0]   ceil_o,
  output logic [IW-1:0]   cur_o,
  output logic            req_o
);
  logic [N-1:0]  en_q, en_d, lat_q, lat_d, admit;
  logic [PW-1:0] ceil_q, ceil_d;
  logic          en_ce, lat_ce;

  always_comb begin
    en_d = en_q;
    if (en_set_i) en_d = en_d | wdata_i;
    if (en_clr_i) en_d = en_d & ~wdata_i;
    en_ce  = en_set_i | en_clr_i;
    lat_d  = (ack_i ? '0 : lat_q) | (rise_i & cap_i);
    lat_ce = ack_i | (|(rise_i & cap_i));
    ceil_d = wdata_i[PW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      lat_q  <= '0;
      ceil_q <= '1;
    end else begin
      if (en_ce)     en_q   <= en_d;
      if (lat_ce)    lat_q  <= lat_d;
      if (ceil_we_i) ceil_q <= ceil_d;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_line
    assign raw_o[i] = cap_i[i] ? lat_q[i] : adj_i[i];
    assign admit[i] = prio_i[i*PW +: PW] <= ceil_q;
  end

  assign stat_o  = raw_o & en_q & admit;
  assign req_o   = |stat_o;
  assign en_o    = en_q;
  assign latch_o = lat_q;
  assign ceil_o  = ceil_q;

  intc_pick #(.N(N), .PW(PW)) u_pick (
    .cand_i (stat_o),
    .prio_i (prio_i),
    .win_o  (cur_o)
  );
endmodule

// File: rtl/intc_dual_bank.sv
module intc_dual_bank
  import intc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  src_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [31:0]       wdata_i,
  input  logic              rd_en_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam int unsigned N    = LINES;
  localparam int unsigned PW   = PRIO_W;
  localparam int unsigned IW   = $clog2(N) + 1;
  localparam int unsigned XW   = $clog2(N);
  localparam int unsigned NB   = 2;
  localparam logic [ADDR_W-1:0] PRIO_END = PRIO_BASE + ADDR_W'(4*N);

  logic [1:0]    rst_sync_q;
  logic          rst_ok;
  logic [N-1:0]  pol_q, cap_q, prev_q, adj, rise;
  logic [PW-1:0] prio_q [N];
  logic [N*PW-1:0] prio_flat;

  logic [N-1:0]  raw_b [NB];
  logic [N-1:0]  en_b  [NB];
  logic [N-1:0]  lat_b [NB];
  logic [N-1:0]  stat_b[NB];
  logic [PW-1:0] ceil_b[NB];
  logic [IW-1:0] cur_b [NB];
  logic          req_b [NB];
  logic          set_b [NB];
  logic          clr_b [NB];
  logic          cw_b  [NB];
  logic          ack_b [NB];

  logic          in_bank, in_prio, bsel;
  logic [7:0]    ofs;
  logic [XW-1:0] pidx;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ok = rst_sync_q[1];

  // address decode
  assign in_bank = (addr_i[ADDR_W-1:9] == '0);
  assign bsel    = addr_i[8];
  assign ofs     = addr_i[7:0];
  assign in_prio = (addr_i >= PRIO_BASE) && (addr_i < PRIO_END) && (addr_i[1:0] == 2'b00);
  assign pidx    = addr_i[XW+1:2];

  // shared line conditioning
  assign adj  = src_i ^ ~pol_q;
  assign rise = adj & ~prev_q;

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      pol_q  <= '1;
      cap_q  <= '0;
      prev_q <= '0;
    end else begin
      prev_q <= adj;
      if (wr_en_i && addr_i == POL_ADDR) pol_q <= wdata_i[N-1:0];
      if (wr_en_i && addr_i == CAP_ADDR) cap_q <= wdata_i[N-1:0];
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_prio
    logic pw_ce;
    assign pw_ce = wr_en_i && in_prio && (pidx == XW'(i));
    always_ff @(posedge clk or negedge rst_ok) begin
      if (!rst_ok)    prio_q[i] <= '0;
      else if (pw_ce) prio_q[i] <= wdata_i[PW-1:0];
    end
    assign prio_flat[i*PW +: PW] = prio_q[i];
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic hit;
    assign hit      = in_bank && (bsel == b[0]);
    assign set_b[b] = wr_en_i && hit && (ofs == OFS_ENSET);
    assign clr_b[b] = wr_en_i && hit && (ofs == OFS_ENCLR);
    assign cw_b[b]  = wr_en_i && hit && (ofs == OFS_CEIL);
    assign ack_b[b] = rd_en_i && hit && (ofs == OFS_ACK);

    intc_bank #(.N(N), .PW(PW)) u_bank (
      .clk      (clk),
      .rst_n    (rst_ok),
      .adj_i    (adj),
      .rise_i   (rise),
      .cap_i    (cap_q),
      .prio_i   (prio_flat),
      .en_set_i (set_b[b]),
      .en_clr_i (clr_b[b]),
      .ceil_we_i(cw_b[b]),
      .ack_i    (ack_b[b]),
      .wdata_i  (wdata_i[N-1:0]),
      .raw_o    (raw_b[b]),
      .en_o     (en_b[b]),
      .latch_o  (lat_b[b]),
      .stat_o   (stat_b[b]),
      .ceil_o   (ceil_b[b]),
      .cur_o    (cur_b[b]),
      .req_o    (req_b[b])
    );
  end

  assign irq_o = req_b[0];
  assign fiq_o = req_b[1];

  // read mux
  always_comb begin
    rdata_o = '0;
    if (in_bank) begin
      case (ofs)
        OFS_STATUS, OFS_ACK:  rdata_o = 32'(stat_b[bsel]);
        OFS_RAW:              rdata_o = 32'(raw_b[bsel]);
        OFS_ENSET, OFS_ENCLR: rdata_o = 32'(en_b[bsel]);
        OFS_CUR:              rdata_o = 32'(cur_b[bsel]);
        OFS_CEIL:             rdata_o = 32'(ceil_b[bsel]);
        default:              rdata_o = '0;
      endcase
    end else if (addr_i == POL_ADDR) begin
      rdata_o = 32'(pol_q);
    end else if (addr_i == CAP_ADDR) begin
      rdata_o = 32'(cap_q);
    end else if (in_prio) begin
      rdata_o = 32'(prio_q[pidx]);
    end
  end
endmodule

// File: rtl/intc_dual_bank_chk.sv
module intc_dual_bank_chk
  import intc_pkg::*;
(
  input logic              clk,
  input logic              rst_ok,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic [31:0]       wdata_i,
  input logic              irq_o,
  input logic              fiq_o,
  input logic [LINES-1:0]  rise,
  input logic [LINES-1:0]  en0,
  input logic [LINES-1:0]  en1,
  input logic [LINES-1:0]  lat0,
  input logic              ack0,
  input logic [$clog2(LINES):0] cur0
);
  localparam int unsigned N = LINES;

  AST_ENSET_LANDS: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_en_i && addr_i == BANK0_BASE + 12'h008) |=> ((en0 & $past(wdata_i)) == $past(wdata_i))); // R2
  AST_ENCLR_LANDS: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_en_i && addr_i == BANK0_BASE + 12'h00C) |=> ((en0 & $past(wdata_i)) == '0)); // R2
  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_ok)
    !ack0 |=> ((lat0 & $past(lat0)) == $past(lat0))); // R4
  AST_ACK_EMPTIES: assert property (@(posedge clk) disable iff (!rst_ok)
    (ack0 && rise == '0) |=> (lat0 == '0)); // R5
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_ok)
    (en0 == '0) |-> !irq_o); // R6
  AST_FIQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_ok)
    (en1 == '0) |-> !fiq_o); // R6
  AST_CUR_IDLE: assert property (@(posedge clk) disable iff (!rst_ok)
    !irq_o |-> (cur0 == N)); // R9
  AST_CUR_VALID: assert property (@(posedge clk) disable iff (!rst_ok)
    irq_o |-> (cur0 < N)); // R9
endmodule

bind intc_dual_bank intc_dual_bank_chk u_chk (
  .clk     (clk),
  .rst_ok  (rst_ok),
  .addr_i  (addr_i),
  .wr_en_i (wr_en_i),
  .wdata_i (wdata_i),
  .irq_o   (irq_o),
  .fiq_o   (fiq_o),
  .rise    (rise),
  .en0     (en_b[0]),
  .en1     (en_b[1]),
  .lat0    (lat_b[0]),
  .ack0    (ack_b[0]),
  .cur0    (cur_b[0])
);

// File: tb/sim_intc_dual_bank.sv
`timescale 1ns/1ps
module sim_intc_dual_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] src;
  logic [11:0] addr;
  logic        wr_en, rd_en;
  logic [31:0] wdata, rdata;
  logic        irq, fiq;
  int          n_chk = 0;
  int          n_bad = 0;
  logic [31:0] v;

  always #2 clk = ~clk;  // 250 MHz

  intc_dual_bank u0 (
    .clk(clk), .rst_n(rst_n), .src_i(src), .addr_i(addr),
    .wr_en_i(wr_en), .wdata_i(wdata), .rd_en_i(rd_en),
    .rdata_o(rdata), .irq_o(irq), .fiq_o(fiq)
  );

  // {src, polarity, enable, expected status, expected current}
  localparam int NV = 6;
  localparam logic [133:0] TBL [NV] = '{
    {32'h0000_0005, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0005, 6'd0},
    {32'h0000_0004, 32'hFFFF_FFFF, 32'h0000_000F, 32'h0000_0004, 6'd2},
    {32'h8000_0000, 32'hFFFF_FFFF, 32'h0000_FFFF, 32'h0000_0000, 6'd32},
    {32'h0000_0000, 32'hFFFF_FFFE, 32'h0000_0001, 32'h0000_0001, 6'd0},
    {32'h0000_0001, 32'hFFFF_FFFE, 32'h0000_0001, 32'h0000_0000, 6'd32},
    {32'hF000_0000, 32'hFFFF_FFFF, 32'hA000_0000, 32'hA000_0000, 6'd29}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b0; #1 d = rdata;
  endtask

  task automatic rd_ack(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; src = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic reset_checks();
    rd(12'h008, v); check("R1 irq enables", v, 32'h0);
    rd(12'h108, v); check("R1 fiq enables", v, 32'h0);
    rd(12'h02C, v); check("R1 irq ceiling", v, 32'hF);
    rd(12'h12C, v); check("R1 fiq ceiling", v, 32'hF);
    rd(12'h200, v); check("R1 polarity", v, 32'hFFFF_FFFF);
    rd(12'h204, v); check("R1 capture", v, 32'h0);
    rd(12'h31C, v); check("R1 prio line 7", v, 32'h0);
    check("R1 irq_o", {31'b0, irq}, 32'h0);
    check("R1 fiq_o", {31'b0, fiq}, 32'h0);
  endtask

  initial begin
    fork
      begin
        do_reset();
        reset_checks();

        // table walk: level lines, polarity, enables, status, current
        for (int k = 0; k < NV; k++) begin
          wr(12'h00C, 32'hFFFF_FFFF);
          wr(12'h200, TBL[k][101:70]);
          wr(12'h008, TBL[k][69:38]);
          @(negedge clk); src = TBL[k][133:102];
          rd(12'h000, v); check("R6/R3 table status", v, TBL[k][37:6]);
          rd(12'h020, v); check("R9 table current", v, {26'b0, TBL[k][5:0]});
          check("R6 table irq_o", {31'b0, irq}, {31'b0, (TBL[k][37:6] != 0)});
        end
        wr(12'h200, 32'hFFFF_FFFF);
        @(negedge clk); src = 32'h0000_0009;
        rd(12'h004, v); check("R3 raw status", v, 32'h0000_0009);

        // R2 partial set/clear
        wr(12'h00C, 32'hFFFF_FFFF);
        wr(12'h008, 32'h0000_000F);
        wr(12'h00C, 32'h0000_0005);
        rd(12'h008, v); check("R2 mask after clear", v, 32'h0000_000A);
        rd(12'h00C, v); check("R2 mask via clear ofs", v, 32'h0000_000A);

        // R8, R9, R7 priority and ceiling
        wr(12'h008, 32'hFFFF_FFFF);
        wr(12'h30C, 32'h5);
        wr(12'h31C, 32'h2);
        wr(12'h328, 32'h2);
        @(negedge clk); src = 32'h0000_0488;
        rd(12'h31C, v); check("R8 prio word", v, 32'h2);
        rd(12'h020, v); check("R9 lowest prio then line", v, 32'd7);
        wr(12'h02C, 32'h1);
        rd(12'h000, v); check("R7 ceiling 1 status", v, 32'h0);
        rd(12'h020, v); check("R7 ceiling 1 current", v, 32'd32);
        check("R7 ceiling 1 irq_o", {31'b0, irq}, 32'h0);
        wr(12'h02C, 32'h2);
        rd(12'h000, v); check("R7 ceiling 2 status", v, 32'h0000_0480);
        wr(12'h02C, 32'hF);
        rd(12'h000, v); check("R7 ceiling F status", v, 32'h0000_0488);

        // R10 bank independence
        check("R10 fiq idle", {31'b0, fiq}, 32'h0);
        check("R10 irq busy", {31'b0, irq}, 32'h1);
        wr(12'h108, 32'h0000_0400);
        rd(12'h100, v); check("R10 fiq status", v, 32'h0000_0400);
        rd(12'h120, v); check("R10 fiq current", v, 32'd10);
        wr(12'h12C, 32'h1);
        check("R10 fiq ceiling own", {31'b0, fiq}, 32'h0);
        check("R10 irq unaffected", {31'b0, irq}, 32'h1);

        // R4, R5 sticky capture and acknowledge
        @(negedge clk); src = '0;
        wr(12'h00C, 32'hFFFF_FFFF);
        wr(12'h10C, 32'hFFFF_FFFF);
        wr(12'h12C, 32'hF);
        wr(12'h204, 32'h0000_0010);
        wr(12'h008, 32'h0000_0010);
        wr(12'h108, 32'h0000_0010);
        @(negedge clk); src = 32'h0000_0010;
        @(negedge clk); src = 32'h0;
        @(negedge clk);
        rd(12'h000, v); check("R4 irq latched pulse", v, 32'h0000_0010);
        rd(12'h100, v); check("R4 fiq latched pulse", v, 32'h0000_0010);
        rd_ack(12'h028, v); check("R5 ack returns status", v, 32'h0000_0010);
        rd(12'h000, v); check("R5 irq cleared", v, 32'h0);
        rd(12'h100, v); check("R5 fiq untouched", v, 32'h0000_0010);
        rd_ack(12'h128, v);
        rd(12'h100, v); check("R5 fiq cleared", v, 32'h0);
        @(negedge clk); src = 32'h0000_0010;
        @(negedge clk);
        rd_ack(12'h028, v);
        rd(12'h000, v); check("R4 held level no re-latch", v, 32'h0);
        wr(12'h204, 32'h0);
        rd(12'h000, v); check("R4 level mode follows", v, 32'h0000_0010);

        // reset again
        do_reset();
        reset_checks();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule